// File: doc/BRIEF.md
# Daisy-Chained ADC Frame Reader

This block is the host side of a serial readout link to a chain of identical multichannel delta-sigma converters. All converters share one chip-select line. The serial output of each converter feeds the daisy input of the next one, so the host sees one long bit stream on a single data input. When the active-low data-ready input falls, the block selects the chain and generates the serial clock. It then collects the status word and the eight channel samples of every converter.

Between two converters the stream carries one extra clock whose bit has no meaning. The block clocks it and drops it. Each finished 24-bit word is handed out for one cycle, together with the number of the converter it came from and its position within that converter's set. A pulse marks the end of the frame. A data-ready edge that arrives while a frame is still being read is not acted on; it only sets a sticky overrun flag.

Top module: `adc_daisy_reader`

## Requirements
- R1: While reset is applied and after it is released, `cs_n` is high, `sclk` is low, and `word_valid`, `frame_done` and `overrun` are low.
- R2: A falling edge on `drdy_n` while the block is idle pulls `cs_n` low within a few clock cycles. `cs_n` then stays low until the frame completes.
- R3: `sclk` stays low for at least one SCLK period (CLK_DIV clock cycles) after `cs_n` falls. `sclk` is never high while `cs_n` is high.
- R4: Words are assembled MSB first from bits sampled on the falling SCLK edge, with the converters updating data on the rising edge. Device 0, the one nearest the host, comes first. Each device delivers its status word and then its channels 1 to 8.
- R5: Exactly one extra SCLK period is inserted between consecutive device data sets, and none after the last device. A frame therefore has N_DEV*216 + N_DEV-1 rising SCLK edges. The value of the extra bit never affects any emitted word.
- R6: `word_valid` is high for one cycle per word, 9*N_DEV times per frame. `word_idx` is 0 for the status word and 1 to 8 for channels 1 to 8, and `word_dev` gives the device number.
- R7: `frame_done` pulses for one cycle together with the last word, which has device N_DEV-1 and index 8. `cs_n` returns high in that same cycle.
- R8: A `drdy_n` falling edge during a readout neither restarts nor disturbs the frame. It sets `overrun`, which stays high until reset.
- R9: Reset applied in the middle of a frame releases `cs_n`, stops `sclk` low and emits no further words. The next data-ready edge then reads a complete frame.
- R10: During shifting, each high phase of `sclk` lasts CLK_DIV/2 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drdy_n | input | 1 | Active-low data-ready from the chain, synchronised inside |
| miso | input | 1 | Serial data from the first converter in the chain |
| cs_n | output | 1 | Shared active-low chip select |
| sclk | output | 1 | Serial clock to all converters |
| word_data | output | WORD_W (24) | Captured word |
| word_dev | output | DEV_W (2) | Device number of the captured word |
| word_idx | output | IDX_W (4) | 0 = status, 1..8 = channel |
| word_valid | output | 1 | One-cycle strobe for a captured word |
| frame_done | output | 1 | One-cycle strobe with the final word of a frame |
| overrun | output | 1 | Sticky flag: data-ready seen during a readout |

## Verification
The converter model drives a different, deliberately misleading value on the extra inter-device bit for each frame. A reader that counts the extra clock as data, or forgets it, shifts every word after device 0 by one bit and fails the per-word comparison. It also breaks the rising-edge total of the frame. An edge on data-ready in the middle of a frame catches a design that restarts the sequence or loses the overrun flag. A reset in the middle of a frame catches a design that leaves `cs_n` low or keeps stale counters for the next frame. The lead time from `cs_n` to the first SCLK and the SCLK high time are measured, which exposes an early clock or a wrong divider.

// File: rtl/adc_daisy_pkg.sv
package adc_daisy_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_LEAD  = 2'd1,
    RD_SHIFT = 2'd2
  } rd_state_t;
endpackage

// File: rtl/adc_drdy_sync.sv
module adc_drdy_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_n,
  output logic fall_o
);
  logic [2:0] sync_q;
  logic [2:0] sync_d;

  always_comb begin
    sync_d = {sync_q[1:0], drdy_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 3'b111;
    else        sync_q <= sync_d;
  end

  assign fall_o = sync_q[2] & ~sync_q[1];
endmodule

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk_o,
  output logic fall_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [PH_W-1:0] ph_q, ph_d;
  logic            sclk_q, sclk_d;
  logic            ph_end;

  assign ph_end = (ph_q == PH_W'(CLK_DIV - 1));

  always_comb begin
    ph_d   = '0;
    sclk_d = 1'b0;
    if (run) begin
      ph_d   = ph_end ? '0 : ph_q + 1'b1;
      sclk_d = sclk_q;
      if (ph_q == PH_W'(HALF - 1)) sclk_d = 1'b1;
      else if (ph_end)             sclk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign fall_o = run & sclk_q & ph_end;
endmodule

// File: rtl/adc_word_shifter.sv
module adc_word_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_o,
  output logic              last_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  assign word_o = {sh_q[WORD_W-2:0], bit_in};
  assign last_o = bit_en && (cnt_q == CNT_W'(WORD_W - 1));

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (clr) begin
      sh_d  = '0;
      cnt_d = '0;
    end else if (bit_en) begin
      sh_d  = word_o;
      cnt_d = last_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/adc_daisy_reader.sv
module adc_daisy_reader
  import adc_daisy_pkg::*;
#(
  parameter int N_DEV   = 4,
  parameter int N_CH    = 8,
  parameter int WORD_W  = 24,
  parameter int CLK_DIV = 4,
  localparam int DEV_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int IDX_W  = $clog2(N_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drdy_n,
  input  logic              miso,
  output logic              cs_n,
  output logic              sclk,
  output logic [WORD_W-1:0] word_data,
  output logic [DEV_W-1:0]  word_dev,
  output logic [IDX_W-1:0]  word_idx,
  output logic              word_valid,
  output logic              frame_done,
  output logic              overrun
);
  localparam int LEAD_W = $clog2(CLK_DIV) + 1;

  rd_state_t         st_q, st_d;
  logic [LEAD_W-1:0] lead_q, lead_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DEV_W-1:0]  dev_q, dev_d;
  logic              gap_q, gap_d;
  logic              cs_q, cs_d;
  logic [WORD_W-1:0] wdat_q, wdat_d;
  logic [DEV_W-1:0]  wdev_q, wdev_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic              wval_q, wval_d;
  logic              done_q, done_d;
  logic              ovr_q, ovr_d;

  logic              drdy_fall;
  logic              sclk_fall;
  logic              shift_run;
  logic              bit_take;
  logic              word_end;
  logic [WORD_W-1:0] word_full;

  adc_drdy_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .drdy_n (drdy_n),
    .fall_o (drdy_fall)
  );

  assign shift_run = (st_q == RD_SHIFT);

  adc_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (shift_run),
    .sclk_o (sclk),
    .fall_o (sclk_fall)
  );

  assign bit_take = sclk_fall & ~gap_q;

  adc_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (st_q == RD_IDLE),
    .bit_en (bit_take),
    .bit_in (miso),
    .word_o (word_full),
    .last_o (word_end)
  );

  always_comb begin
    st_d   = st_q;
    lead_d = lead_q;
    idx_d  = idx_q;
    dev_d  = dev_q;
    gap_d  = gap_q;
    cs_d   = cs_q;
    wdat_d = wdat_q;
    wdev_d = wdev_q;
    widx_d = widx_q;
    wval_d = 1'b0;
    done_d = 1'b0;
    ovr_d  = ovr_q | (drdy_fall & (st_q != RD_IDLE));
    unique case (st_q)
      RD_IDLE: begin
        if (drdy_fall) begin
          st_d   = RD_LEAD;
          cs_d   = 1'b1;
          lead_d = '0;
          idx_d  = '0;
          dev_d  = '0;
          gap_d  = 1'b0;
        end
      end
      RD_LEAD: begin
        lead_d = lead_q + 1'b1;
        if (lead_q == LEAD_W'(CLK_DIV - 1)) st_d = RD_SHIFT;
      end
      RD_SHIFT: begin
        if (sclk_fall && gap_q) begin
          gap_d = 1'b0;
        end else if (word_end) begin
          wval_d = 1'b1;
          wdat_d = word_full;
          wdev_d = dev_q;
          widx_d = idx_q;
          if (idx_q == IDX_W'(N_CH)) begin
            idx_d = '0;
            if (dev_q == DEV_W'(N_DEV - 1)) begin
              done_d = 1'b1;
              cs_d   = 1'b0;
              st_d   = RD_IDLE;
            end else begin
              dev_d = dev_q + 1'b1;
              gap_d = 1'b1;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: begin
        st_d = RD_IDLE;
        cs_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      lead_q <= '0;
      idx_q  <= '0;
      dev_q  <= '0;
      gap_q  <= 1'b0;
      cs_q   <= 1'b0;
      wdat_q <= '0;
      wdev_q <= '0;
      widx_q <= '0;
      wval_q <= 1'b0;
      done_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      lead_q <= lead_d;
      idx_q  <= idx_d;
      dev_q  <= dev_d;
      gap_q  <= gap_d;
      cs_q   <= cs_d;
      wdat_q <= wdat_d;
      wdev_q <= wdev_d;
      widx_q <= widx_d;
      wval_q <= wval_d;
      done_q <= done_d;
      ovr_q  <= ovr_d;
    end
  end

  assign cs_n       = ~cs_q;
  assign word_data  = wdat_q;
  assign word_dev   = wdev_q;
  assign word_idx   = widx_q;
  assign word_valid = wval_q;
  assign frame_done = done_q;
  assign overrun    = ovr_q;

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n); // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R6
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> (word_idx <= IDX_W'(N_CH))); // R6
  AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (word_valid && word_dev == DEV_W'(N_DEV - 1) && word_idx == IDX_W'(N_CH))); // R7
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> frame_done); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R8
  AST_NO_CLK_AT_GAP_END: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !sclk); // R5
endmodule

// File: tb/sim_adc_daisy_reader.sv
module sim_adc_daisy_reader;
  localparam int N_DEV   = 4;
  localparam int N_CH    = 8;
  localparam int CLK_DIV = 4;
  localparam int DEV_BITS = (N_CH + 1) * 24;
  localparam int N_BITS   = N_DEV * DEV_BITS + N_DEV - 1;
  localparam int N_WORDS  = N_DEV * (N_CH + 1);
  localparam int NV = 5;
  localparam logic [23:0] SEED [NV] = '{24'hA5A5A5, 24'h000000, 24'hFFFFFF, 24'h123456, 24'h800001};
  localparam logic        JUNK [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic        OVR_AT [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  logic        clk, rst_n, drdy_n, miso;
  logic        cs_n, sclk, word_valid, frame_done, overrun;
  logic [23:0] word_data;
  logic [1:0]  word_dev;
  logic [3:0]  word_idx;

  int n_chk = 0;
  int n_err = 0;
  logic [23:0] cur_seed = 24'h0;
  logic        cur_junk = 1'b0;
  int exp_cnt = 0, rise_cnt = 0, lead_cnt = 0, hi_run = 0, bidx = 0;
  bit done_seen = 0, lead_done = 0, prev_cs = 1, prev_sclk = 0, finished = 0;

  adc_daisy_reader #(.N_DEV(N_DEV), .N_CH(N_CH), .WORD_W(24), .CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .drdy_n(drdy_n), .miso(miso),
    .cs_n(cs_n), .sclk(sclk), .word_data(word_data), .word_dev(word_dev),
    .word_idx(word_idx), .word_valid(word_valid), .frame_done(frame_done),
    .overrun(overrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [23:0] exp_word(logic [23:0] seed, int d, int w);
    return seed ^ {4'(d), 4'(w), 8'(d * 9 + w), 8'(w * 17)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // converter chain model: new bit after each rising SCLK, index cleared when deselected
  initial begin
    miso = 1'b0;
    forever begin
      @(posedge sclk or posedge cs_n);
      if (cs_n) bidx = 0;
      else begin
        automatic int p = bidx;
        automatic int dv = p / (DEV_BITS + 1);
        automatic int r = p % (DEV_BITS + 1);
        automatic logic [23:0] wv;
        if (p >= N_BITS || r == DEV_BITS) miso <= cur_junk;
        else begin
          wv = exp_word(cur_seed, dv, r / 24);
          miso <= wv[23 - (r % 24)];
        end
        bidx++;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (prev_cs && !cs_n) begin
        exp_cnt = 0; rise_cnt = 0; done_seen = 0; lead_cnt = 0; lead_done = 0;
      end
      if (!cs_n && !lead_done) begin
        if (sclk) begin
          lead_done = 1;
          chk(lead_cnt >= CLK_DIV, "R3 lead time", lead_cnt, CLK_DIV);
        end else lead_cnt++;
      end
      if (sclk && !prev_sclk) rise_cnt++;
      if (sclk) hi_run++;
      else if (hi_run != 0) begin
        chk(hi_run == CLK_DIV / 2, "R10 sclk high time", hi_run, CLK_DIV / 2);
        hi_run = 0;
      end
      if (word_valid) begin
        automatic int d = exp_cnt / (N_CH + 1);
        automatic int w = exp_cnt % (N_CH + 1);
        automatic logic [23:0] e = exp_word(cur_seed, d, w);
        chk(word_data == e, "R4 word data", int'(word_data), int'(e));
        chk(int'(word_dev) == d, "R6 word_dev", int'(word_dev), d);
        chk(int'(word_idx) == w, "R6 word_idx", int'(word_idx), w);
        exp_cnt++;
      end
      if (frame_done) begin
        done_seen = 1;
        chk(exp_cnt == N_WORDS, "R6 words per frame", exp_cnt, N_WORDS);
        chk(cs_n == 1'b1, "R7 cs_n released with done", int'(cs_n), 1);
        chk(rise_cnt == N_BITS, "R5 sclk edges incl extra clocks", rise_cnt, N_BITS);
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  task automatic pulse_drdy();
    @(negedge clk) drdy_n = 1'b0;
    repeat (4) @(negedge clk);
    drdy_n = 1'b1;
  endtask

  task automatic run_frame(input logic [23:0] seed, input logic junk, input bit mid_ovr);
    int t;
    cur_seed = seed;
    cur_junk = junk;
    pulse_drdy();
    t = 0;
    while (cs_n && t < 10) begin @(negedge clk); t++; end
    chk(cs_n == 1'b0, "R2 cs_n asserted after drdy", int'(cs_n), 0);
    if (mid_ovr) begin
      repeat (1000) @(negedge clk);
      pulse_drdy();
    end
    while (!done_seen) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R7 idle after frame", int'({cs_n, sclk}), 2);
  endtask

  initial begin
    rst_n = 1'b0;
    drdy_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R1 cs_n/sclk idle", int'({cs_n, sclk}), 2);
    chk({word_valid, frame_done, overrun} == 3'b000, "R1 strobes low",
        int'({word_valid, frame_done, overrun}), 0);

    for (int i = 0; i < NV; i++) begin
      run_frame(SEED[i], JUNK[i], OVR_AT[i]);
      chk(overrun == (i >= 2), "R8 overrun sticky", int'(overrun), int'(i >= 2));
    end

    // reset in the middle of a frame
    cur_seed = 24'h5A0F3C;
    cur_junk = 1'b1;
    pulse_drdy();
    while (exp_cnt < 5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R9 abort releases cs_n, sclk low", int'({cs_n, sclk}), 2);
    chk(overrun == 1'b0, "R8 overrun cleared by reset", int'(overrun), 0);
    repeat (3) @(negedge clk);
    chk(word_valid == 1'b0, "R9 no words after abort", int'(word_valid), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(cs_n == 1'b1 && word_valid == 1'b0, "R9 stays idle after abort",
        int'({cs_n, word_valid}), 2);
    run_frame(24'h3C3C3C, 1'b0, 1'b0);
    chk(overrun == 1'b0, "R8 no overrun in clean frame", int'(overrun), 0);

    finish_up();
  end
endmodule